// File: doc/BRIEF.md
# Next Program Counter and Link Generator

This block works out where a 32-bit RISC-V integer core fetches next. Each cycle it takes the current program counter, the two register operands, an already sign-extended immediate and a decoded transfer class, and returns the following program counter, a flag that says the flow left straight-line order, the return address for a link instruction and a write enable for that return address. Conditional branches support six comparisons, in signed and unsigned forms. The register-indirect jump clears bit 0 of its computed target.

The computation is combinational. An optional program counter register, selected by a parameter, loads the computed next address on every clock edge. A synchronous active-high reset loads it with a parameterised start address. Decoding of raw instruction words, the register file and traps on misaligned targets belong to neighbouring blocks.

Top module: `nxpc_unit`

## Requirements
- R1: With `xfer_kind` = 0 (straight-line), `next_pc` is `cur_pc` + 4, `taken` is 0 and `link_we` is 0.
- R2: With `xfer_kind` = 1 (branch) and a true condition, `next_pc` is `cur_pc` + `imm`, where `imm` may be negative, and `taken` is 1. With a false condition, `next_pc` is `cur_pc` + 4 and `taken` is 0.
- R3: `cmp_kind` 3'b000 branches when `opa` equals `opb`. `cmp_kind` 3'b001 branches when they differ.
- R4: `cmp_kind` 3'b100 branches when `opa` < `opb` as signed two's-complement values. `cmp_kind` 3'b101 branches when `opa` >= `opb` signed.
- R5: `cmp_kind` 3'b110 branches when `opa` < `opb` as unsigned values. `cmp_kind` 3'b111 branches when `opa` >= `opb` unsigned.
- R6: `cmp_kind` 3'b010 and 3'b011 never branch, whatever the operands.
- R7: With `xfer_kind` = 2 (direct jump), `next_pc` is `cur_pc` + `imm` and `taken` is 1.
- R8: With `xfer_kind` = 3 (register jump), `next_pc` is (`opa` + `imm`) with bit 0 forced to 0, and `taken` is 1.
- R9: `link_we` is 1 only when `xfer_kind` is 2 or 3 and `link_idx` is nonzero. It is 0 when the destination index is 0.
- R10: `link_val` is `cur_pc` + 4 for every transfer class.
- R11: While `rst` is high at a rising edge, `pc_q` becomes `RESET_VEC` (default 32'h2000_0000) after that edge.
- R12: With `rst` low at a rising edge, `pc_q` takes the `next_pc` value that was present before that edge.
- R13: All address sums wrap modulo 2^32. For example, `cur_pc` = 32'hFFFF_FFFC gives a sequential `next_pc` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the program counter register |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Address of the current instruction |
| opa | input | 32 | First register operand (base for register jump) |
| opb | input | 32 | Second register operand |
| imm | input | 32 | Sign-extended immediate |
| xfer_kind | input | 2 | 0 straight-line, 1 branch, 2 direct jump, 3 register jump |
| cmp_kind | input | 3 | Branch comparison selector |
| link_idx | input | 5 | Destination register index of the link |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Flow leaves straight-line order |
| link_val | output | 32 | Return address |
| link_we | output | 1 | Return address should be written |
| pc_q | output | 32 | Registered program counter |

## Verification
`next_pc`, `taken`, `link_val` and `link_we` are combinational. They settle in the same cycle as the inputs that produce them. `pc_q` changes only at the rising edge that follows.

The driver changes inputs on falling edges and queues the expected item. The monitor pops that item one nanosecond after the next rising edge. At that moment the combinational outputs still reflect the inputs applied half a cycle earlier, and `pc_q` already holds the value loaded at that edge. Both kinds of result are therefore checked at the single point where each is due.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  typedef enum logic [1:0] {
    XFER_SEQ    = 2'd0,
    XFER_BRANCH = 2'd1,
    XFER_JAL    = 2'd2,
    XFER_JALR   = 2'd3
  } xfer_e;

  typedef enum logic [2:0] {
    CMP_EQ   = 3'b000,
    CMP_NE   = 3'b001,
    CMP_RSV2 = 3'b010,
    CMP_RSV3 = 3'b011,
    CMP_LT   = 3'b100,
    CMP_GE   = 3'b101,
    CMP_LTU  = 3'b110,
    CMP_GEU  = 3'b111
  } cmp_e;

  localparam int INSN_BYTES = 4;
  localparam int CMP_CODES  = 8;
endpackage

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
  import nxpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  cmp_e            kind,
  output logic            hit
);
  function automatic logic is_eq(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return (a == b);
  endfunction

  function automatic logic is_lt_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return ($signed(a) < $signed(b));
  endfunction

  function automatic logic is_lt_unsigned(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return (a < b);
  endfunction

  logic                 eq_w, lts_w, ltu_w;
  logic [CMP_CODES-1:0] hit_vec;

  assign eq_w  = is_eq(lhs, rhs);
  assign lts_w = is_lt_signed(lhs, rhs);
  assign ltu_w = is_lt_unsigned(lhs, rhs);

  // Bit 0 of the code inverts the base test of each pair
  genvar g;
  generate
    for (g = 0; g < CMP_CODES; g++) begin : g_code
      if (g / 2 == 0) begin : g_eq
        assign hit_vec[g] = eq_w ^ g[0];
      end else if (g / 2 == 1) begin : g_rsv
        assign hit_vec[g] = 1'b0;
      end else if (g / 2 == 2) begin : g_lts
        assign hit_vec[g] = lts_w ^ g[0];
      end else begin : g_ltu
        assign hit_vec[g] = ltu_w ^ g[0];
      end
    end
  endgenerate

  assign hit = hit_vec[kind];
endmodule

// File: rtl/nxpc_target_gen.sv
module nxpc_target_gen #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] ofs,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] rel_pc,
  output logic [XLEN-1:0] ind_pc
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] clear_lsb(input logic [XLEN-1:0] a);
    return {a[XLEN-1:1], 1'b0};
  endfunction

  assign seq_pc = wrap_add(pc, STEP_V);
  assign rel_pc = wrap_add(pc, ofs);
  assign ind_pc = clear_lsb(wrap_add(base, ofs));
endmodule

// File: rtl/nxpc_select.sv
module nxpc_select
  import nxpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  xfer_e           kind,
  input  logic            br_hit,
  input  logic            link_nz,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] rel_pc,
  input  logic [XLEN-1:0] ind_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);
  always_comb begin
    next_pc = seq_pc;
    taken   = 1'b0;
    link_we = 1'b0;
    unique case (kind)
      XFER_SEQ: begin
        next_pc = seq_pc;
      end
      XFER_BRANCH: begin
        taken   = br_hit;
        next_pc = br_hit ? rel_pc : seq_pc;
      end
      XFER_JAL: begin
        taken   = 1'b1;
        next_pc = rel_pc;
        link_we = link_nz;
      end
      XFER_JALR: begin
        taken   = 1'b1;
        next_pc = ind_pc;
        link_we = link_nz;
      end
      default: ;
    endcase
  end

  assign link_val = seq_pc;
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          REG_W     = 5,
  parameter bit          REG_STAGE = 1'b1,
  parameter logic [31:0] RESET_VEC = 32'h2000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [XLEN-1:0]  imm,
  input  logic [1:0]       xfer_kind,
  input  logic [2:0]       cmp_kind,
  input  logic [REG_W-1:0] link_idx,
  output logic [XLEN-1:0]  next_pc,
  output logic             taken,
  output logic [XLEN-1:0]  link_val,
  output logic             link_we,
  output logic [XLEN-1:0]  pc_q
);
  localparam logic [XLEN-1:0] RST_V = XLEN'(RESET_VEC);

  xfer_e           kind_w;
  cmp_e            cmp_w;
  logic            br_hit;
  logic            link_nz;
  logic [XLEN-1:0] seq_pc, rel_pc, ind_pc;

  assign kind_w  = xfer_e'(xfer_kind);
  assign cmp_w   = cmp_e'(cmp_kind);
  assign link_nz = |link_idx;

  nxpc_cond_eval #(.XLEN(XLEN)) u_cond (
    .lhs (opa),
    .rhs (opb),
    .kind(cmp_w),
    .hit (br_hit)
  );

  nxpc_target_gen #(.XLEN(XLEN), .STEP(INSN_BYTES)) u_tgt (
    .pc    (cur_pc),
    .base  (opa),
    .ofs   (imm),
    .seq_pc(seq_pc),
    .rel_pc(rel_pc),
    .ind_pc(ind_pc)
  );

  nxpc_select #(.XLEN(XLEN)) u_sel (
    .kind    (kind_w),
    .br_hit  (br_hit),
    .link_nz (link_nz),
    .seq_pc  (seq_pc),
    .rel_pc  (rel_pc),
    .ind_pc  (ind_pc),
    .next_pc (next_pc),
    .taken   (taken),
    .link_val(link_val),
    .link_we (link_we)
  );

  generate
    if (REG_STAGE) begin : g_pcreg
      logic [XLEN-1:0] pc_r;
      always_ff @(posedge clk) begin
        if (rst) pc_r <= RST_V;
        else     pc_r <= next_pc;
      end
      assign pc_q = pc_r;

      // R11
      pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == RST_V));

      // R12
      pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(next_pc)));
    end else begin : g_nopcreg
      assign pc_q = next_pc;
    end
  endgenerate

  // R1
  seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_w == XFER_SEQ) |-> (!taken && !link_we && next_pc == link_val));

  // R6
  rsv_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_w == CMP_RSV2 || cmp_w == CMP_RSV3) |-> !br_hit);

  // R8
  jalr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_w == XFER_JALR) |-> (taken && next_pc[0] == 1'b0));

  // R9
  link_gate_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> ((kind_w == XFER_JAL || kind_w == XFER_JALR) && link_nz));

  // R2
  untaken_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_w == XFER_BRANCH && !br_hit) |-> (!taken && next_pc == seq_pc));
endmodule

// File: tb/nxpc_unit_test.sv
module nxpc_unit_test;
  localparam logic [31:0] RV = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0, opa = '0, opb = '0, imm = '0;
  logic [1:0]  xfer_kind = '0;
  logic [2:0]  cmp_kind = '0;
  logic [4:0]  link_idx = '0;
  logic [31:0] next_pc, link_val, pc_q;
  logic        taken, link_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] nx;
    logic        tk;
    logic [31:0] lk;
    logic        we;
    logic [31:0] pq;
    string       req;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;

  nxpc_unit #(.RESET_VEC(RV)) uut (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .opa(opa), .opb(opb), .imm(imm),
    .xfer_kind(xfer_kind), .cmp_kind(cmp_kind), .link_idx(link_idx),
    .next_pc(next_pc), .taken(taken), .link_val(link_val), .link_we(link_we),
    .pc_q(pc_q)
  );

  function automatic bit cond(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    bit slt;
    slt = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000));
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return slt;
      3'b101: return !slt;
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [1:0] k, input logic [2:0] c,
                       input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] im, input logic [4:0] idx, input string req);
    item_t it;
    bit    t;
    @(negedge clk);
    rst = r; xfer_kind = k; cmp_kind = c; cur_pc = pc;
    opa = a; opb = b; imm = im; link_idx = idx;
    t = (k == 2'd2) || (k == 2'd3) || (k == 2'd1 && cond(c, a, b));
    it.tk  = t;
    it.lk  = pc + 32'd4;
    it.we  = (k[1] == 1'b1) && (idx != 5'd0);
    if (k == 2'd3)   it.nx = (a + im) & 32'hFFFF_FFFE;
    else if (t)      it.nx = pc + im;
    else             it.nx = pc + 32'd4;
    it.pq  = r ? RV : it.nx;
    it.req = req;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk(it.req, "next_pc", next_pc, it.nx);
        chk(it.req, "taken", {31'd0, taken}, {31'd0, it.tk});
        chk(it.req, "link_val", link_val, it.lk);
        chk(it.req, "link_we", {31'd0, link_we}, {31'd0, it.we});
        chk(it.req, "pc_q", pc_q, it.pq);
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "pc_q after reset", pc_q, RV);
    // R1 R12 R10: straight-line, first cycle out of reset
    drive(1'b0, 2'd0, 3'b000, 32'h0000_1000, 32'd5, 32'd5, 32'd64, 5'd3, "R1");
    // R13 wrap of the sequential address
    drive(1'b0, 2'd0, 3'b000, 32'hFFFF_FFFC, 32'd0, 32'd0, 32'd0, 5'd0, "R13");
    // R3 equal / not equal
    drive(1'b0, 2'd1, 3'b000, 32'h0000_2000, 32'd7, 32'd7, 32'h0000_0010, 5'd0, "R3");
    drive(1'b0, 2'd1, 3'b000, 32'h0000_2000, 32'd7, 32'd8, 32'h0000_0010, 5'd0, "R3");
    drive(1'b0, 2'd1, 3'b001, 32'h0000_2000, 32'd7, 32'd8, 32'h0000_0010, 5'd0, "R3");
    drive(1'b0, 2'd1, 3'b001, 32'h0000_2000, 32'd9, 32'd9, 32'h0000_0010, 5'd0, "R3");
    // R4 signed: -1 < 1
    drive(1'b0, 2'd1, 3'b100, 32'h0000_3000, 32'hFFFF_FFFF, 32'd1, 32'h0000_0100, 5'd0, "R4");
    drive(1'b0, 2'd1, 3'b101, 32'h0000_3000, 32'hFFFF_FFFF, 32'd1, 32'h0000_0100, 5'd0, "R4");
    drive(1'b0, 2'd1, 3'b101, 32'h0000_3000, 32'd4, 32'd4, 32'h0000_0100, 5'd0, "R4");
    // R5 unsigned: 0xFFFFFFFF is large
    drive(1'b0, 2'd1, 3'b110, 32'h0000_4000, 32'hFFFF_FFFF, 32'd1, 32'h0000_0040, 5'd0, "R5");
    drive(1'b0, 2'd1, 3'b111, 32'h0000_4000, 32'hFFFF_FFFF, 32'd1, 32'h0000_0040, 5'd0, "R5");
    drive(1'b0, 2'd1, 3'b110, 32'h0000_4000, 32'd1, 32'h8000_0000, 32'h0000_0040, 5'd0, "R5");
    // R6 reserved codes never branch
    drive(1'b0, 2'd1, 3'b010, 32'h0000_5000, 32'd3, 32'd3, 32'h0000_0080, 5'd0, "R6");
    drive(1'b0, 2'd1, 3'b011, 32'h0000_5000, 32'd1, 32'd2, 32'h0000_0080, 5'd0, "R6");
    // R2 backwards taken branch
    drive(1'b0, 2'd1, 3'b000, 32'h0000_6000, 32'd0, 32'd0, 32'hFFFF_FFF0, 5'd0, "R2");
    // R7 direct jump, R10 link
    drive(1'b0, 2'd2, 3'b000, 32'h0000_7000, 32'd0, 32'd0, 32'h0000_0800, 5'd1, "R7");
    // R9 direct jump to x0
    drive(1'b0, 2'd2, 3'b000, 32'h0000_7000, 32'd0, 32'd0, 32'hFFFF_F000, 5'd0, "R9");
    // R8 register jump with odd sum, and negative offset
    drive(1'b0, 2'd3, 3'b000, 32'h0000_8000, 32'h0001_0001, 32'd0, 32'h0000_0004, 5'd1, "R8");
    drive(1'b0, 2'd3, 3'b110, 32'h0000_8000, 32'h0001_0000, 32'd0, 32'hFFFF_FFFF, 5'd0, "R8");
    // R10 link on a branch class
    drive(1'b0, 2'd1, 3'b001, 32'hFFFF_FFFC, 32'd1, 32'd2, 32'd8, 5'd31, "R10");
    // R11 reset mid-run, then R12 release
    drive(1'b1, 2'd2, 3'b000, 32'h0000_9000, 32'd0, 32'd0, 32'h0000_0020, 5'd2, "R11");
    drive(1'b0, 2'd0, 3'b000, 32'h0000_A000, 32'd0, 32'd0, 32'd0, 5'd0, "R12");
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule